// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a DMA controller. Software programs a source address, a destination address, a byte count, a request-line select and a burst length through a word-addressed register write port. It then sets the enable bit in the control word, and the channel copies data one beat at a time over a simple memory master port. Each beat is a read from the source followed by a write to the destination. Each side has its own port size and its own addressing mode. Linear addressing steps the address up or down. The FIFO modes keep the address fixed, which suits a peripheral data register.

The channel can run freely, or it can wait for a selected peripheral request line before each burst. A force bit starts a single burst without a request. When a block finishes, the channel emits a one-cycle completion pulse. With repeat set, it reloads the addresses and the count that are programmed at that moment and continues without stopping, so software can queue the next buffer while the current one is still moving. An error response from memory halts the channel and raises a transfer-error flag.

Top module: `dma_channel`

## Requirements
- R1: Register word index `reg_waddr` selects the register: 0 source address, 1 destination address, 2 byte count (low 24 bits kept), 3 control, 4 request-line select, 5 burst length (6 bits). Index 6 and above are accepted and ignored. Control bits: 0 enable, 1 force, 2 repeat, 3 request enable, 5:4 source size, 7:6 destination size, 9 decrement, 11:10 source mode, 13:12 destination mode, 14 auto-clear repeat. Size codes are 0 = 32-bit, 1 = 8-bit, 2 = 16-bit. Mode codes are 0 = linear, 1 = 2D (handled as linear), 2 = FIFO, 3 = end-of-burst FIFO. `mem_size` uses the same size codes.
- R2: Each beat moves the narrower of the two port widths. Data is right-justified on `mem_rdata`/`mem_wdata`, and a read always precedes its write. The count drops by the beat width per beat, and the beat that starts with a remaining count at or below the beat width is the last one.
- R3: A linear side steps its address by the beat width after every beat, downward when decrement is set. A FIFO or end-of-burst FIFO side keeps its address fixed.
- R4: A burst is the burst-length value in bytes, with 0 meaning 64. With request enable set, each burst starts only while the selected bit of `dreq_in` is high. With it clear, bursts follow each other without waiting.
- R5: Writing the force bit starts one burst without a request. The bit then clears itself.
- R6: At the end of a block, `done` is high for exactly one cycle. If repeat is clear, the enable bit clears and no further memory access occurs.
- R7: With repeat set, the end of a block reloads the addresses and count currently held in the registers, including values written during the block, and the channel continues.
- R8: With auto-clear repeat also set, the repeat bit clears at the reload, so exactly one further block runs.
- R9: A memory error response ends the beat, stops the channel without a `done` pulse, and sets `xfer_err`. The flag stays set until the control register is written with enable set.
- R10: Enabling with a zero count gives a `done` pulse and makes no memory access.
- R11: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack` or `mem_err` is seen.
- R12: After reset, `mem_req`, `done` and `xfer_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| dreq_in | input | NREQ | Peripheral request lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data, right-justified |
| mem_rdata | input | DW | Read data, right-justified |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| done | output | 1 | One-cycle block completion pulse |
| xfer_err | output | 1 | Transfer error flag |

## Verification
The copy path is tried with a set of transfers that pair different source and destination widths. Together they cover linear-to-linear copies, a narrow source feeding a fixed FIFO target, a FIFO source feeding linear memory, decrementing copies, a 2D code treated as linear, and the 64-byte default burst. Mismatched widths separate the beat-width choice from either single port size. Fixed-address targets separate FIFO modes from linear stepping, because only the last beat survives at the FIFO address. The decrement pattern shows the step direction. A run with a memory that stalls every other cycle shows that the handshake holds each request. Directed sequences cover request gating with the wrong line and the right line, the force bit, mid-block reprogramming under repeat, the single chained block under auto-clear, the error stop and a zero count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        PSZ_32  = 2'd0,
        PSZ_8   = 2'd1,
        PSZ_16  = 2'd2,
        PSZ_RSV = 2'd3
    } port_size_e;

    typedef enum logic [1:0] {
        AM_LINEAR  = 2'd0,
        AM_2D      = 2'd1,
        AM_FIFO    = 2'd2,
        AM_EOBFIFO = 2'd3
    } addr_mode_e;

    // Control word, bit 0 is the LSB of the packed struct.
    typedef struct packed {
        logic       acrpt;   // 14
        addr_mode_e dmode;   // 13:12
        addr_mode_e smode;   // 11:10
        logic       dec;     // 9
        logic       msel;    // 8
        port_size_e dsize;   // 7:6
        port_size_e ssize;   // 5:4
        logic       ren;     // 3
        logic       rpt;     // 2
        logic       frc;     // 1
        logic       en;      // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [3:0] {
        RI_SRC  = 4'd0,
        RI_DST  = 4'd1,
        RI_CNT  = 4'd2,
        RI_CTRL = 4'd3,
        RI_RSEL = 4'd4,
        RI_BLEN = 4'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } state_e;

    function automatic logic [2:0] size_bytes(port_size_e s);
        case (s)
            PSZ_8:   return 3'd1;
            PSZ_16:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [2:0] beat_bytes(port_size_e a, port_size_e b);
        logic [2:0] x;
        logic [2:0] y;
        x = size_bytes(a);
        y = size_bytes(b);
        return (x < y) ? x : y;
    endfunction

    function automatic port_size_e size_code(logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return PSZ_8;
            3'd2:    return PSZ_16;
            default: return PSZ_32;
        endcase
    endfunction

    function automatic logic [6:0] burst_bytes(logic [5:0] bl);
        return (bl == 6'd0) ? 7'd64 : {1'b0, bl};
    endfunction

    function automatic logic is_fixed(addr_mode_e m);
        return (m == AM_FIFO) || (m == AM_EOBFIFO);
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  addr_mode_e    mode,
    input  logic          dec,
    input  logic [2:0]    step,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (is_fixed(mode))
            nxt = cur;
        else if (dec)
            nxt = cur - AW'(step);
        else
            nxt = cur + AW'(step);
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 24,
    parameter int RSW = 2,
    parameter int BLW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [3:0]     wr_idx,
    input  logic [31:0]    wr_data,
    input  logic           en_clr,
    input  logic           rpt_clr,
    input  logic           frc_clr,
    output ctrl_t          ctrl,
    output logic [AW-1:0]  src_prog,
    output logic [AW-1:0]  dst_prog,
    output logic [CW-1:0]  cnt_prog,
    output logic [RSW-1:0] rsel,
    output logic [BLW-1:0] blen,
    output logic           start
);
    assign start = wr_en && (wr_idx == RI_CTRL) && wr_data[0] && !ctrl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            src_prog <= '0;
            dst_prog <= '0;
            cnt_prog <= '0;
            rsel     <= '0;
            blen     <= '0;
        end else begin
            if (en_clr)  ctrl.en  <= 1'b0;
            if (rpt_clr) ctrl.rpt <= 1'b0;
            if (frc_clr) ctrl.frc <= 1'b0;
            if (wr_en) begin
                case (wr_idx)
                    RI_SRC:  src_prog <= wr_data[AW-1:0];
                    RI_DST:  dst_prog <= wr_data[AW-1:0];
                    RI_CNT:  cnt_prog <= wr_data[CW-1:0];
                    RI_CTRL: ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    RI_RSEL: rsel     <= wr_data[RSW-1:0];
                    RI_BLEN: blen     <= wr_data[BLW-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R8: auto-clear drops repeat once it is used
    a_r8_rpt_clears: assert property (@(posedge clk) disable iff (rst)
        (rpt_clr && !wr_en) |=> !ctrl.rpt);
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 24,
    parameter int BLW = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctrl,
    input  logic [AW-1:0]  src_prog,
    input  logic [AW-1:0]  dst_prog,
    input  logic [CW-1:0]  cnt_prog,
    input  logic [BLW-1:0] blen,
    input  logic           req_hit,
    input  logic           start,
    output logic           en_clr,
    output logic           rpt_clr,
    output logic           frc_clr,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    input  logic           mem_err,
    output logic           done,
    output logic           xfer_err
);
    state_e         state;
    logic [AW-1:0]  src_cur, dst_cur;
    logic [CW-1:0]  cnt_cur;
    logic [6:0]     burst_left;
    logic [DW-1:0]  data_q;
    logic           done_q, err_q;

    logic [2:0]     bw;
    logic           last_beat, go, arm_fire, wr_ok, any_err, blk_end, reload;
    logic           start_ok, load_now;
    logic [CW-1:0]  cnt_after;
    logic [6:0]     burst_after;

    logic [AW-1:0]  side_cur [2];
    logic [AW-1:0]  side_nxt [2];
    addr_mode_e     side_mode [2];

    assign side_cur[0]  = src_cur;
    assign side_cur[1]  = dst_cur;
    assign side_mode[0] = ctrl.smode;
    assign side_mode[1] = ctrl.dmode;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_side
            dma_addr_step #(.AW(AW)) u_step (
                .cur  (side_cur[g]),
                .mode (side_mode[g]),
                .dec  (ctrl.dec),
                .step (bw),
                .nxt  (side_nxt[g])
            );
        end
    endgenerate

    assign bw          = beat_bytes(ctrl.ssize, ctrl.dsize);
    assign last_beat   = (cnt_cur <= CW'(bw));
    assign cnt_after   = last_beat ? '0 : cnt_cur - CW'(bw);
    assign burst_after = (burst_left <= 7'(bw)) ? 7'd0 : burst_left - 7'(bw);
    assign go          = !ctrl.ren || req_hit || ctrl.frc;
    assign arm_fire    = (state == ST_ARM) && ctrl.en && (cnt_cur != '0) && go;
    assign wr_ok       = (state == ST_WR) && mem_ack && !mem_err;
    assign any_err     = mem_req && mem_err;
    assign blk_end     = ((state == ST_ARM) && ctrl.en && (cnt_cur == '0)) || (wr_ok && last_beat);
    assign reload      = blk_end && ctrl.rpt;
    assign start_ok    = start && ((state == ST_IDLE) || (state == ST_ARM));
    assign load_now    = start_ok || reload;

    assign en_clr  = (blk_end && !ctrl.rpt) || any_err;
    assign rpt_clr = reload && ctrl.acrpt;
    assign frc_clr = arm_fire && ctrl.frc;

    assign mem_req   = (state == ST_RD) || (state == ST_WR);
    assign mem_we    = (state == ST_WR);
    assign mem_addr  = (state == ST_WR) ? dst_cur : src_cur;
    assign mem_size  = size_code(bw);
    assign mem_wdata = data_q;
    assign done      = done_q;
    assign xfer_err  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            src_cur    <= '0;
            dst_cur    <= '0;
            cnt_cur    <= '0;
            burst_left <= '0;
            data_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= blk_end;
            if (any_err) err_q <= 1'b1;
            if (start_ok) err_q <= 1'b0;
            case (state)
                ST_IDLE: ;
                ST_ARM: begin
                    if (!ctrl.en)
                        state <= ST_IDLE;
                    else if (cnt_cur == '0)
                        state <= ctrl.rpt ? ST_ARM : ST_IDLE;
                    else if (go) begin
                        burst_left <= burst_bytes(blen);
                        state      <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_err)
                        state <= ST_IDLE;
                    else if (mem_ack) begin
                        data_q <= mem_rdata;
                        state  <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_err)
                        state <= ST_IDLE;
                    else if (mem_ack) begin
                        src_cur    <= side_nxt[0];
                        dst_cur    <= side_nxt[1];
                        cnt_cur    <= cnt_after;
                        burst_left <= burst_after;
                        if (last_beat)
                            state <= ctrl.rpt ? ST_ARM : ST_IDLE;
                        else if (!ctrl.en)
                            state <= ST_IDLE;
                        else if (burst_after == 7'd0)
                            state <= ST_ARM;
                        else
                            state <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (load_now) begin
                src_cur <= src_prog;
                dst_cur <= dst_prog;
                cnt_cur <= cnt_prog;
                state   <= ST_ARM;
            end
        end
    end

    // R11: a pending access holds its request, address and direction
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: an error response ends activity and raises the flag
    a_r9_err_stop: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err) |=> (!mem_req && xfer_err));

    // R4: without a request or force, an armed channel issues no access
    a_r4_wait_req: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_ARM) && ctrl.ren && !req_hit && !ctrl.frc && !start) |=> !mem_req);

    // R3: a fixed destination keeps its address across beats
    a_r3_fifo_fixed: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !last_beat && is_fixed(ctrl.dmode) && !load_now) |=> (dst_cur == $past(dst_cur)));

    // R2: outside a load, the remaining count never grows
    a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
        !load_now |=> (cnt_cur <= $past(cnt_cur)));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_chan_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int CW   = 24,
    parameter int NREQ = 4,
    parameter int BLW  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_we,
    input  logic [3:0]      reg_waddr,
    input  logic [31:0]     reg_wdata,
    input  logic [NREQ-1:0] dreq_in,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    input  logic            mem_err,
    output logic            done,
    output logic            xfer_err
);
    localparam int RSW = (NREQ > 1) ? $clog2(NREQ) : 1;

    ctrl_t          ctrl;
    logic [AW-1:0]  src_prog, dst_prog;
    logic [CW-1:0]  cnt_prog;
    logic [RSW-1:0] rsel;
    logic [BLW-1:0] blen;
    logic           start, en_clr, rpt_clr, frc_clr, req_hit;

    assign req_hit = dreq_in[rsel];

    dma_chan_regs #(.AW(AW), .CW(CW), .RSW(RSW), .BLW(BLW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we),
        .wr_idx   (reg_waddr),
        .wr_data  (reg_wdata),
        .en_clr   (en_clr),
        .rpt_clr  (rpt_clr),
        .frc_clr  (frc_clr),
        .ctrl     (ctrl),
        .src_prog (src_prog),
        .dst_prog (dst_prog),
        .cnt_prog (cnt_prog),
        .rsel     (rsel),
        .blen     (blen),
        .start    (start)
    );

    dma_chan_fsm #(.AW(AW), .DW(DW), .CW(CW), .BLW(BLW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .src_prog  (src_prog),
        .dst_prog  (dst_prog),
        .cnt_prog  (cnt_prog),
        .blen      (blen),
        .req_hit   (req_hit),
        .start     (start),
        .en_clr    (en_clr),
        .rpt_clr   (rpt_clr),
        .frc_clr   (frc_clr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .done      (done),
        .xfer_err  (xfer_err)
    );
endmodule

// File: tb/dma_channel_test.sv
module dma_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  dreq_in = '0;
    logic        mem_req, mem_we, done, xfer_err;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int writes = 0;
    int done_cnt = 0;
    int dbl_done = 0;
    bit done_prev = 1'b0;
    bit stall = 1'b0;
    bit stall_tog = 1'b0;

    logic [7:0] mem [256];
    logic [7:0] expm [256];

    localparam logic [7:0] ERR_ADDR = 8'hF0;

    always #2 clk = ~clk;

    dma_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .dreq_in(dreq_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .done(done), .xfer_err(xfer_err)
    );

    function automatic int nbytes(logic [1:0] code);
        return (code == 2'd1) ? 1 : (code == 2'd2) ? 2 : 4;
    endfunction

    // Memory model: answers at the falling edge, seen by the design at the next rising edge
    always @(negedge clk) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
        if (done && done_prev) dbl_done++;
        done_prev = done;
        if (done) done_cnt++;
        if (!rst && mem_req) begin
            stall_tog = ~stall_tog;
            if (!stall || stall_tog) begin
                if (mem_addr[7:0] == ERR_ADDR) mem_err = 1'b1;
                else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        for (int k = 0; k < nbytes(mem_size); k++)
                            mem[8'(mem_addr[7:0] + k)] = mem_wdata[8*k +: 8];
                        writes++;
                    end else begin
                        for (int k = 0; k < 4; k++)
                            mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + k)];
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
        end
    endtask

    task automatic wreg(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 4'(idx); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            expm[i] = 8'(i * 7 + 3);
        end
    endtask

    // Reference copy built from the requirements (R2, R3)
    task automatic model(input int sa, input int da, input int cnt, input logic [1:0] ss,
                         input logic [1:0] ds, input logic [1:0] sm, input logic [1:0] dm,
                         input bit dc, output int beats);
        int b, s, d, c;
        b = (nbytes(ss) < nbytes(ds)) ? nbytes(ss) : nbytes(ds);
        s = sa; d = da; c = cnt; beats = 0;
        while (c > 0) begin
            for (int k = 0; k < b; k++) expm[8'(d + k)] = expm[8'(s + k)];
            if (sm < 2) s = dc ? s - b : s + b;
            if (dm < 2) d = dc ? d - b : d + b;
            c = (c <= b) ? 0 : c - b;
            beats++;
        end
    endtask

    function automatic int mism();
        int n = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) n++;
        return n;
    endfunction

    task automatic wait_done(input int target);
        for (int i = 0; i < 3000 && done_cnt < target; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    typedef struct packed {
        logic [1:0] ss, ds, sm, dm;
        logic       dc;
        logic [7:0] cnt;
        logic [5:0] bl;
        logic [7:0] sa, da;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 8'd16, 6'd8, 8'h00, 8'h80},
        '{2'd1, 2'd0, 2'd0, 2'd2, 1'b0, 8'd5,  6'd4, 8'h10, 8'hC0},
        '{2'd2, 2'd2, 2'd2, 2'd0, 1'b0, 8'd6,  6'd2, 8'h20, 8'h40},
        '{2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 8'd12, 6'd0, 8'h3C, 8'h9C},
        '{2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 8'd72, 6'd0, 8'h00, 8'h60},
        '{2'd2, 2'd0, 2'd0, 2'd3, 1'b0, 8'd4,  6'd2, 8'h50, 8'hD0},
        '{2'd0, 2'd2, 2'd1, 2'd0, 1'b0, 8'd8,  6'd8, 8'h70, 8'hE0}
    };

    task automatic run_vec(input vec_t v, input string tag);
        int beats, w0, d0;
        init_mem();
        model(int'(v.sa), int'(v.da), int'(v.cnt), v.ss, v.ds, v.sm, v.dm, v.dc, beats);
        wreg(0, 32'(v.sa)); wreg(1, 32'(v.da)); wreg(2, 32'(v.cnt)); wreg(5, 32'(v.bl));
        w0 = writes; d0 = done_cnt;
        wreg(3, 32'(1) | (32'(v.ss) << 4) | (32'(v.ds) << 6) | (32'(v.dc) << 9)
                | (32'(v.sm) << 10) | (32'(v.dm) << 12));
        wait_done(d0 + 1);
        chk(mism() == 0, {tag, " data"}, mism(), 0);
        chk(writes - w0 == beats, {tag, " beat count"}, writes - w0, beats);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0, d0, bt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!mem_req && !done && !xfer_err, "R12 reset outputs", {mem_req, done, xfer_err}, 0);

        // R1 R2 R3: vector table
        for (int v = 0; v < 7; v++) run_vec(VECS[v], $sformatf("R1/R2/R3 vec%0d", v));

        // R11 stalling memory
        stall = 1'b1;
        run_vec(VECS[0], "R11 stalled");
        stall = 1'b0;

        // R10 zero count
        w0 = writes; d0 = done_cnt;
        wreg(2, 0); wreg(3, 1);
        repeat (10) @(negedge clk);
        chk(done_cnt - d0 == 1, "R10 done on zero count", done_cnt - d0, 1);
        chk(writes == w0, "R10 no access", writes - w0, 0);

        // R4 request gating, line 2 selected, burst 8 bytes
        init_mem();
        wreg(0, 32'h00); wreg(1, 32'h80); wreg(2, 16); wreg(4, 2); wreg(5, 8);
        w0 = writes; d0 = done_cnt;
        dreq_in = 4'b0010;
        wreg(3, 32'h9);
        repeat (20) @(negedge clk);
        chk(writes == w0 && !mem_req, "R4 wrong line ignored", writes - w0, 0);
        dreq_in = 4'b0100; @(negedge clk); dreq_in = 4'b0000;
        repeat (30) @(negedge clk);
        chk(writes - w0 == 2, "R4 one burst per request", writes - w0, 2);
        dreq_in = 4'b0100; @(negedge clk); dreq_in = 4'b0000;
        repeat (30) @(negedge clk);
        chk(done_cnt - d0 == 1, "R4 block done after two bursts", done_cnt - d0, 1);

        // R5 force bit
        w0 = writes;
        wreg(3, 32'hB);
        repeat (30) @(negedge clk);
        chk(writes - w0 == 2, "R5 forced single burst", writes - w0, 2);
        wreg(3, 0);
        repeat (5) @(negedge clk);

        // R7 repeat with mid-block reprogramming
        init_mem();
        model(0, 'h80, 16, 0, 0, 0, 0, 1'b0, bt);
        model('h40, 'hA0, 8, 0, 0, 0, 0, 1'b0, bt);
        wreg(0, 32'h00); wreg(1, 32'h80); wreg(2, 16); wreg(5, 0);
        d0 = done_cnt;
        wreg(3, 32'hD);
        wreg(0, 32'h40); wreg(1, 32'hA0); wreg(2, 8);
        dreq_in = 4'b0100;
        wait_done(d0 + 3);
        chk(done_cnt - d0 >= 3, "R7 channel keeps running", done_cnt - d0, 3);
        wreg(3, 0); dreq_in = '0;
        repeat (10) @(negedge clk);
        chk(mism() == 0, "R7 reloaded addresses used", mism(), 0);

        // R8 auto-clear repeat, then R6 stop
        wreg(0, 32'h00); wreg(1, 32'h80); wreg(2, 8);
        w0 = writes; d0 = done_cnt;
        wreg(3, 32'h4005);
        repeat (200) @(negedge clk);
        chk(done_cnt - d0 == 2, "R8 exactly two blocks", done_cnt - d0, 2);
        chk(writes - w0 == 4, "R8 beat count", writes - w0, 4);
        w0 = writes;
        repeat (50) @(negedge clk);
        chk(writes == w0 && !mem_req, "R6 idle after block", writes - w0, 0);
        chk(dbl_done == 0, "R6 done lasts one cycle", dbl_done, 0);

        // R9 error response
        w0 = writes; d0 = done_cnt;
        wreg(0, 32'(ERR_ADDR)); wreg(2, 8);
        wreg(3, 1);
        repeat (20) @(negedge clk);
        chk(xfer_err === 1'b1, "R9 error flag", xfer_err, 1);
        chk(writes == w0 && done_cnt == d0 && !mem_req, "R9 stopped without done",
            done_cnt - d0, 0);
        wreg(0, 32'h00);
        wreg(3, 1);
        chk(xfer_err === 1'b0, "R9 flag cleared by enable", xfer_err, 0);
        wait_done(d0 + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule